// File: doc/BRIEF.md
# Packed Half-Precision Compare-and-Set Unit

This unit compares two 32-bit operands lane by lane and returns a 32-bit mask word. Each operand normally carries two FP16 lanes. A per-operand lane mode can instead route one half into both lanes, or read the whole word as a single FP32 value that feeds both lanes.

Each lane compare gives a single bit. That bit is merged with a shared, optionally inverted, input predicate through a selectable boolean operator. A lane that ends up true writes either FP16 1.0 or an all-ones half-word, depending on a flag. A lane that ends up false writes zero.

The unit has one register stage. Operands and controls present at a rising clock edge appear on `result` directly after that edge.

Top module: `hset_unit`

## Requirements
- R1: While `rstN` is low, `result` is 0x00000000.
- R2: `result` takes the value computed from the inputs sampled at a rising edge right after that edge, and holds it until the next edge.
- R3: Lane mode encoding is the same for both operands. 0 means the low lane is bits 15:0 and the high lane is bits 31:16. 1 means bits 31:0 form one FP32 value used for both lanes. 2 means bits 15:0 feed both lanes. 3 means bits 31:16 feed both lanes.
- R4: When one side is FP32 and the other is FP16, the FP16 value is widened exactly, subnormals included, so the compare gives the true numeric ordering.
- R5: Each operand has its own absolute-value flag (clears the sign) and negate flag (flips the sign). Absolute value is applied before negation, and both lanes of an operand use that operand's flags.
- R6: `cmpCode` bit 0 selects "less", bit 1 selects "equal" and bit 2 selects "greater". If either side is NaN, the compare result is `cmpCode[3]`. Otherwise the result is the OR of the selected relations. +0 and -0 are equal, and infinities order normally.
- R7: With `ftzEn` high, subnormal inputs in both formats compare as zero of the same sign. With `ftzEn` low, they compare at their exact value.
- R8: The effective predicate is `predIn` XOR `predInv`.
- R9: `bopCode` merges each lane's compare bit with the effective predicate: 0 and 3 mean AND, 1 means OR, 2 means XOR.
- R10: A true lane writes 0x3C00 when `boolFloat` is high and 0xFFFF when it is low. A false lane writes 0x0000. The low-lane result goes to bits 15:0 and the high-lane result to bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | Operand A word |
| opB | input | 32 | Operand B word |
| swzA | input | 2 | Lane mode for operand A |
| swzB | input | 2 | Lane mode for operand B |
| absA | input | 1 | Absolute value on operand A |
| negA | input | 1 | Negate operand A |
| absB | input | 1 | Absolute value on operand B |
| negB | input | 1 | Negate operand B |
| cmpCode | input | 4 | Compare condition |
| bopCode | input | 2 | Predicate merge operator |
| predIn | input | 1 | Input predicate |
| predInv | input | 1 | Invert input predicate |
| ftzEn | input | 1 | Treat subnormals as zero |
| boolFloat | input | 1 | True pattern select: FP16 1.0 or all ones |
| result | output | 32 | Packed lane result mask |

## Verification
Some properties hold whatever the operand values are, and the assertions check those on every cycle:
- each result half is either zero or the selected true pattern;
- an AND merge with a false effective predicate gives zero;
- the never and always condition codes with an OR merge give fixed words;
- replicated or FP32 lane modes give two identical halves.

The numeric side can only be shown by the bench's sweeps: the ordering of subnormals, signed zeros, infinities and NaNs; exact widening across precisions; the abs/neg order; and flush-to-zero.

// File: rtl/hset_pkg.sv
package hset_pkg;
  localparam int WORD_W    = 32;
  localparam int LANE_W    = 16;
  localparam int NUM_LANES = WORD_W / LANE_W;
  localparam int H_EXP_W   = 5;
  localparam int H_MAN_W   = 10;
  localparam int S_EXP_W   = 8;
  localparam int S_MAN_W   = 23;
  localparam int H_BIAS    = 15;
  localparam int S_BIAS    = 127;
  localparam int MAN_PAD   = S_MAN_W - H_MAN_W;

  typedef enum logic [1:0] {
    SWZ_PAIR = 2'd0,
    SWZ_WIDE = 2'd1,
    SWZ_LOW  = 2'd2,
    SWZ_HIGH = 2'd3
  } swz_e;

  typedef enum logic [1:0] {
    BOP_AND  = 2'd0,
    BOP_OR   = 2'd1,
    BOP_XOR  = 2'd2,
    BOP_AND2 = 2'd3
  } bop_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0]        swzA;
    logic [1:0]        swzB;
    logic              absA;
    logic              negA;
    logic              absB;
    logic              negB;
    logic              ftz;
    logic              takeLt;
    logic              takeEq;
    logic              takeGt;
    logic              takeUnord;
    logic              selOr;
    logic              selXor;
    logic              predEff;
    logic [LANE_W-1:0] trueWord;
  } ctrl_t;

  // exact FP16 -> FP32 conversion, subnormals normalised
  function automatic logic [WORD_W-1:0] widen16(input logic [LANE_W-1:0] h);
    logic [H_EXP_W-1:0] e;
    logic [H_MAN_W-1:0] m;
    logic [S_EXP_W-1:0] e32;
    logic [S_MAN_W-1:0] m32;
    int p;
    e = h[LANE_W-2 -: H_EXP_W];
    m = h[H_MAN_W-1:0];
    p = 0;
    if (&e) begin
      e32 = '1;
      m32 = {m, {MAN_PAD{1'b0}}};
    end else if (e != '0) begin
      e32 = S_EXP_W'(e) + S_EXP_W'(S_BIAS - H_BIAS);
      m32 = {m, {MAN_PAD{1'b0}}};
    end else if (m == '0) begin
      e32 = '0;
      m32 = '0;
    end else begin
      for (int i = 0; i < H_MAN_W; i++) if (m[i]) p = i;
      e32 = S_EXP_W'(p + S_BIAS - H_BIAS - H_MAN_W + 1);
      m32 = S_MAN_W'({m, {MAN_PAD{1'b0}}} << (H_MAN_W - p));
    end
    return {h[LANE_W-1], e32, m32};
  endfunction
endpackage

// File: rtl/hset_ctrl.sv
module hset_ctrl
  import hset_pkg::*;
(
  input  logic [1:0] swzA,
  input  logic [1:0] swzB,
  input  logic       absA,
  input  logic       negA,
  input  logic       absB,
  input  logic       negB,
  input  logic [3:0] cmpCode,
  input  logic [1:0] bopCode,
  input  logic       predIn,
  input  logic       predInv,
  input  logic       ftzEn,
  input  logic       boolFloat,
  output ctrl_t      ctl
);
  localparam logic [LANE_W-1:0] ONE_HALF = 16'h3C00;

  always_comb begin
    ctl           = '0;
    ctl.swzA      = swzA;
    ctl.swzB      = swzB;
    ctl.absA      = absA;
    ctl.negA      = negA;
    ctl.absB      = absB;
    ctl.negB      = negB;
    ctl.ftz       = ftzEn;
    ctl.takeLt    = cmpCode[0];
    ctl.takeEq    = cmpCode[1];
    ctl.takeGt    = cmpCode[2];
    ctl.takeUnord = cmpCode[3];
    ctl.selOr     = (bopCode == BOP_OR);
    ctl.selXor    = (bopCode == BOP_XOR);
    ctl.predEff   = predIn ^ predInv;
    ctl.trueWord  = boolFloat ? ONE_HALF : '1;
  end
endmodule

// File: rtl/hset_operand.sv
module hset_operand
  import hset_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        swz,
  input  logic              absF,
  input  logic              negF,
  input  logic              ftz,
  output logic [WORD_W-1:0] laneVal [NUM_LANES]
);
  logic [NUM_LANES-1:0][LANE_W-1:0] halves;
  assign halves = word;

  logic wideSub;
  assign wideSub = (word[WORD_W-2 -: S_EXP_W] == '0);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] pick;
    logic [WORD_W-1:0] wide;
    always_comb begin
      case (swz)
        SWZ_LOW:  pick = halves[0];
        SWZ_HIGH: pick = halves[NUM_LANES-1];
        default:  pick = halves[g];
      endcase
      if (swz == SWZ_WIDE)
        wide = (ftz && wideSub) ? {word[WORD_W-1], {(WORD_W-1){1'b0}}} : word;
      else if (ftz && pick[LANE_W-2 -: H_EXP_W] == '0)
        wide = widen16({pick[LANE_W-1], {(LANE_W-1){1'b0}}});
      else
        wide = widen16(pick);
    end
    // abs first, then negate
    assign laneVal[g] = {(wide[WORD_W-1] & ~absF) ^ negF, wide[WORD_W-2:0]};
  end
endmodule

// File: rtl/hset_cmp.sv
module hset_cmp
  import hset_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              lt,
  output logic              eq,
  output logic              gt,
  output logic              unord
);
  logic nanA, nanB, zeroBoth, sameBits, magLess, signA, signB;
  logic [WORD_W-2:0] magA, magB;

  assign signA = a[WORD_W-1];
  assign signB = b[WORD_W-1];
  assign magA  = a[WORD_W-2:0];
  assign magB  = b[WORD_W-2:0];
  assign nanA  = (&a[WORD_W-2 -: S_EXP_W]) && (a[S_MAN_W-1:0] != '0);
  assign nanB  = (&b[WORD_W-2 -: S_EXP_W]) && (b[S_MAN_W-1:0] != '0);

  assign unord    = nanA | nanB;
  assign zeroBoth = (magA == '0) && (magB == '0);
  assign sameBits = (a == b);
  assign magLess  = (magA < magB);

  always_comb begin
    eq = ~unord & (zeroBoth | sameBits);
    lt = 1'b0;
    if (!unord && !eq) begin
      if (signA != signB) lt = signA;
      else if (signA)     lt = (magA > magB);
      else                lt = magLess;
    end
    gt = ~unord & ~eq & ~lt;
  end
endmodule

// File: rtl/hset_dp.sv
module hset_dp
  import hset_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  ctrl_t             ctl,
  output logic [WORD_W-1:0] packedOut
);
  logic [WORD_W-1:0] laneA [NUM_LANES];
  logic [WORD_W-1:0] laneB [NUM_LANES];

  hset_operand u_opA (
    .word(opA), .swz(ctl.swzA), .absF(ctl.absA), .negF(ctl.negA),
    .ftz(ctl.ftz), .laneVal(laneA)
  );
  hset_operand u_opB (
    .word(opB), .swz(ctl.swzB), .absF(ctl.absB), .negF(ctl.negB),
    .ftz(ctl.ftz), .laneVal(laneB)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_cmp
    logic lt, eq, gt, unord, hit, merged;
    hset_cmp u_cmp (
      .a(laneA[g]), .b(laneB[g]), .lt(lt), .eq(eq), .gt(gt), .unord(unord)
    );
    assign hit = unord ? ctl.takeUnord
                       : ((lt & ctl.takeLt) | (eq & ctl.takeEq) | (gt & ctl.takeGt));
    always_comb begin
      if (ctl.selXor)     merged = hit ^ ctl.predEff;
      else if (ctl.selOr) merged = hit | ctl.predEff;
      else                merged = hit & ctl.predEff;
    end
    assign packedOut[g*LANE_W +: LANE_W] = merged ? ctl.trueWord : '0;
  end
endmodule

// File: rtl/hset_unit.sv
module hset_unit
  import hset_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  swzA,
  input  logic [1:0]  swzB,
  input  logic        absA,
  input  logic        negA,
  input  logic        absB,
  input  logic        negB,
  input  logic [3:0]  cmpCode,
  input  logic [1:0]  bopCode,
  input  logic        predIn,
  input  logic        predInv,
  input  logic        ftzEn,
  input  logic        boolFloat,
  output logic [31:0] result
);
  ctrl_t             ctl;
  logic [WORD_W-1:0] nextWord;

  hset_ctrl u_ctrl (
    .swzA(swzA), .swzB(swzB), .absA(absA), .negA(negA), .absB(absB),
    .negB(negB), .cmpCode(cmpCode), .bopCode(bopCode), .predIn(predIn),
    .predInv(predInv), .ftzEn(ftzEn), .boolFloat(boolFloat), .ctl(ctl)
  );

  hset_dp u_dp (.opA(opA), .opB(opB), .ctl(ctl), .packedOut(nextWord));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= nextWord;
  end
endmodule

// File: rtl/hset_chk.sv
module hset_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [1:0]  swzA,
  input logic [1:0]  swzB,
  input logic        absA,
  input logic        negA,
  input logic        absB,
  input logic        negB,
  input logic [3:0]  cmpCode,
  input logic [1:0]  bopCode,
  input logic        predIn,
  input logic        predInv,
  input logic        ftzEn,
  input logic        boolFloat,
  input logic [31:0] result
);
  logic [15:0] expTrue;
  assign expTrue = boolFloat ? 16'h3C00 : 16'hFFFF;

  assert_lane_pattern_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((result[15:0] == 16'h0) || (result[15:0] == $past(expTrue))) &&
                    ((result[31:16] == 16'h0) || (result[31:16] == $past(expTrue))));

  // R8 and R9: AND merge with a false effective predicate clears both lanes
  assert_and_false_pred_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past((bopCode == 2'd0 || bopCode == 2'd3) && !(predIn ^ predInv))
      |-> result == 32'h0);

  assert_or_always_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(bopCode == 2'd1 && cmpCode == 4'hF)
      |-> result == {2{$past(expTrue)}});

  assert_never_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(bopCode == 2'd0 && cmpCode == 4'h0) |-> result == 32'h0);

  assert_replicate_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past((swzA == 2'd2 && swzB == 2'd2) || (swzA == 2'd1 && swzB == 2'd1))
      |-> result[15:0] == result[31:16]);
endmodule

bind hset_unit hset_chk u_chk (.*);

// File: tb/sim_hset_unit.sv
`timescale 1ns/1ps
module sim_hset_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  swzA = '0, swzB = '0, bopCode = '0;
  logic        absA = 0, negA = 0, absB = 0, negB = 0;
  logic [3:0]  cmpCode = '0;
  logic        predIn = 0, predInv = 0, ftzEn = 0, boolFloat = 0;
  logic [31:0] result;

  int nTests = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  hset_unit u0 (.*);

  function automatic real p2(input int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic void h2r(input logic [15:0] h, input bit ftz, output real v, output bit nan);
    int e = int'(h[14:10]);
    int m = int'(h[9:0]);
    nan = 0;
    if (e == 31) begin nan = (m != 0); v = 1.0e300; end
    else if (e == 0) v = ftz ? 0.0 : real'(m) * p2(-24);
    else v = real'(1024 + m) * p2(e - 25);
    if (h[15]) v = -v;
  endfunction

  function automatic void s2r(input logic [31:0] w, input bit ftz, output real v, output bit nan);
    int e = int'(w[30:23]);
    int m = int'(w[22:0]);
    nan = 0;
    if (e == 255) begin nan = (m != 0); v = 1.0e300; end
    else if (e == 0) v = ftz ? 0.0 : real'(m) * p2(-149);
    else v = real'(8388608 + m) * p2(e - 150);
    if (w[31]) v = -v;
  endfunction

  function automatic void laneVal(input logic [31:0] w, input logic [1:0] s, input int lane,
                                  input bit ab, input bit ng, output real v, output bit nan);
    logic [15:0] h;
    if (s == 2'd1) s2r(w, ftzEn, v, nan);
    else begin
      h = (s == 2'd2) ? w[15:0] : (s == 2'd3) ? w[31:16] : (lane == 0 ? w[15:0] : w[31:16]);
      h2r(h, ftzEn, v, nan);
    end
    if (ab && v < 0.0) v = -v;
    if (ng) v = -v;
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] w = '0;
    for (int L = 0; L < 2; L++) begin
      real va, vb;
      bit na, nb, c, p, r;
      laneVal(opA, swzA, L, absA, negA, va, na);
      laneVal(opB, swzB, L, absB, negB, vb, nb);
      if (na || nb) c = cmpCode[3];
      else c = (va < vb && cmpCode[0]) || (va == vb && cmpCode[1]) || (va > vb && cmpCode[2]);
      p = predIn ^ predInv;
      case (bopCode)
        2'd1: r = c | p;
        2'd2: r = c ^ p;
        default: r = c & p;
      endcase
      if (r) w[L*16 +: 16] = boolFloat ? 16'h3C00 : 16'hFFFF;
    end
    return w;
  endfunction

  task automatic check(input logic [31:0] expv, input string tag);
    nTests++;
    if (result !== expv) begin
      nFails++;
      $display("FAIL %s: result=%08h expected=%08h (a=%08h b=%08h code=%0d bop=%0d)",
               tag, result, expv, opA, opB, cmpCode, bopCode);
    end
  endtask

  // inputs set at a falling edge, checked at the next falling edge (one register)
  task automatic step(input string tag);
    @(negedge clk);
    check(model(), tag);
  endtask

  logic [15:0] hv [12];
  logic [31:0] sv [8];

  initial begin
    hv = '{16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h03FF, 16'h3C00,
           16'hBC00, 16'h3C01, 16'h7BFF, 16'h7C00, 16'hFC00, 16'h7E00};
    sv = '{32'h3F800000, 32'h00000000, 32'h80000000, 32'h7F800000,
           32'h7FC00000, 32'h33800000, 32'h477FE000, 32'h00000001};

    // R1: reset value
    repeat (3) @(negedge clk);
    check(32'h0, "R1");
    rstN = 1'b1;

    // R2, R6, R7, R10: sweep of value pairs and all condition codes
    predIn = 1'b1;
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int c = 0; c < 16; c++) begin
            ftzEn = f[0];
            boolFloat = c[0] ^ i[0];
            opA = {hv[j], hv[i]};
            opB = {hv[i], hv[j]};
            cmpCode = 4'(c);
            step(f == 1 ? "R7 R6 R10" : "R2 R6 R10");
          end

    // R8, R9: merge operator and predicate inversion on a known compare
    opA = {16'h3C00, 16'h0000};
    opB = {16'h3C00, 16'h3C00};
    cmpCode = 4'd1;
    ftzEn = 0;
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 4; p++) begin
        bopCode = 2'(b);
        predIn = p[0];
        predInv = p[1];
        step("R8 R9");
      end

    // R3, R4, R5, R8, R9: random modes, modifiers and mixed precision
    for (int n = 0; n < 6000; n++) begin
      swzA = 2'($urandom_range(0, 3));
      swzB = 2'($urandom_range(0, 3));
      opA = {hv[$urandom_range(0, 11)], hv[$urandom_range(0, 11)]};
      opB = {hv[$urandom_range(0, 11)], hv[$urandom_range(0, 11)]};
      if ($urandom_range(0, 3) == 0) opA = $urandom();
      if (swzA == 2'd1) opA = ($urandom_range(0, 1) == 0) ? sv[$urandom_range(0, 7)] : $urandom();
      if (swzB == 2'd1) opB = ($urandom_range(0, 1) == 0) ? sv[$urandom_range(0, 7)] : $urandom();
      {absA, negA, absB, negB} = 4'($urandom_range(0, 15));
      cmpCode = 4'($urandom_range(0, 15));
      bopCode = 2'($urandom_range(0, 3));
      {predIn, predInv, ftzEn, boolFloat} = 4'($urandom_range(0, 15));
      step("R3 R4 R5 R8 R9");
    end

    // R2: output holds with unchanged inputs
    @(negedge clk);
    check(model(), "R2");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFails++;
    $display("FAIL watchdog: result=%08h expected=completion", result);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule